// File: doc/BRIEF.md
# GPIO Pad Configuration and Output-Data Controller

This block holds a 16-bit configuration word per pin and one latched output-data bit per pin. It turns them into the control signals for each pad: the value to drive, the output enable, the input enable, the weak pull controls, the hysteresis, the slew and the drive strength. Software reaches the block over a simple 32-bit register bus that takes a word address. Each access walks a three-state sequencer. `ST_IDLE` accepts a request and moves to `ST_ACCESS`. `ST_ACCESS` applies a write and captures read data, then moves to `ST_ACK`. `ST_ACK` raises the acknowledge for one cycle and returns to `ST_IDLE`. `ST_IDLE` stays put while no request is present.

The word address splits into a region (bits 7:6) and a word index (bits 5:0). Any address bit above bit 7 that is set makes the access unmapped.

Region 0 holds the configuration words, two pins per 32-bit word. The even pin sits in bits 31:16 and the odd pin in bits 15:0.

Region 1 holds the output-data bits, and region 2 holds the synchronized input levels. Both use four pins per word and one pin per byte lane. Pin 4k+j sits in bit 0 of lane 3-j, so pin 4k is at bit 24 and pin 4k+3 is at bit 0. Region 3 is unmapped.

A function select of zero makes the pin a GPIO. Any other value hands the pad to one of three alternate-function inputs.

Top module: `gpio_pad_ctrl`

Configuration field positions below are LSB-numbered within the 16-bit word:

| Bits | Field |
|------|-------|
| 11:10 | function select |
| 9 | output buffer enable |
| 8 | input buffer enable |
| 7:6 | drive strength |
| 5 | open-drain enable |
| 4 | hysteresis |
| 3:2 | slew |
| 1 | pull enable |
| 0 | pull select (1 = up) |

## Requirements
- R1: After reset, every configuration word is 0, except the boot pin (`BOOT_PIN`, default 5), which reads 0x0001. All output-data bits are 0, no pad output enable is set, and `bus_ack` is low.
- R2: Configuration bits 15:12 always read 0. On standard pins, bits 7:6 also read 0, so a write of 0xFFFF reads back 0x0F3F. The pull enable, pull select, hysteresis and slew fields drive `pad_pull_en`, `pad_pull_up`, `pad_hys` and `pad_slew` directly.
- R3: On drive-strength pins (`DS_MASK`, default pin 7), bits 7:6 are writable and drive `pad_drive`, and bits 3:2 read 0. A write of 0xFFFF reads back 0x0FF3.
- R4: An output-data write changes only the pins whose byte lane is enabled in `bus_be`. Only bit 0 of each lane is stored. Output data never changes without a write.
- R5: A GPIO pin (function 0) without open-drain has `pad_oe` equal to its output buffer enable and `pad_do` equal to its stored data. With the output buffer disabled, writes are still stored and read back.
- R6: A value written while the pin is an input appears on `pad_do` as soon as the output buffer enable is written to 1, with no further data write.
- R7: With function f in 1..3, pin p drives `alt_do[3p+f-1]` with enable `alt_oe[3p+f-1]`. Output-data writes to that pin have no effect on the pad but are stored.
- R8: With open-drain enabled, the pad never drives high. Data 1 releases `pad_oe`, and data 0 drives low with `pad_oe` set.
- R9: Input-only pins (`INPUT_ONLY_MASK`, default pins 0 and 1) never assert `pad_oe`. Their output-data bits read 0 and ignore writes. Their configuration words remain writable.
- R10: Output-data bits of absent pins (`ABSENT_MASK`, default pin 6) read 0 and ignore writes. Words with no pins and region 3 read 0.
- R11: `pad_di` passes through a two-flop synchronizer. The input-level region shows a pin only when its input buffer enable is 1 and reads 0 for it otherwise. `pad_ie` follows that enable.
- R12: A request seen in `ST_IDLE` is acknowledged two cycles later with a single-cycle `bus_ack`, and `bus_rdata` is valid in that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Access request, sampled in idle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address |
| bus_be | input | 4 | Byte-lane enables for writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with ack |
| bus_ack | output | 1 | One-cycle access completion |
| alt_do | input | 3*NUM_PINS | Alternate-function output values, three per pin |
| alt_oe | input | 3*NUM_PINS | Alternate-function output enables, three per pin |
| pad_di | input | NUM_PINS | Raw pad input levels |
| pad_do | output | NUM_PINS | Pad output values |
| pad_oe | output | NUM_PINS | Pad output enables |
| pad_ie | output | NUM_PINS | Pad input buffer enables |
| pad_pull_en | output | NUM_PINS | Weak pull enables |
| pad_pull_up | output | NUM_PINS | Weak pull direction, 1 = up |
| pad_hys | output | NUM_PINS | Hysteresis enables |
| pad_slew | output | 2*NUM_PINS | Slew controls, two bits per pin |
| pad_drive | output | 2*NUM_PINS | Drive-strength controls, two bits per pin |

## Verification
The bench aims at the following corner cases:

- **Preloaded data, then a direction flip.** Output data is written while the pin is still an input, and then the output buffer is enabled. A design that only updates the pad on a data write would keep the pad low.
- **Narrow byte-lane writes.** Writes enable a single byte lane or two adjacent ones. A decoder that ignores the lane enables would corrupt the neighbouring pins in the same word.
- **Input-only pins, absent pins and empty words.** These are written with all ones. A design that keeps storage there would read the ones back, or would drive an input-only pad.
- **Open-drain on both data values.** Both values are tried, which catches a pad that drives high.
- **Input readback with the buffer enable off.** An ungated readback would leak the raw pin level.

// File: rtl/gpio_pad_pkg.sv
package gpio_pad_pkg;

    localparam int CFG_W       = 16;
    localparam int ALT_PER_PIN = 3;
    localparam int FSEL_W      = 2;

    // LSB-numbered field positions within one configuration word
    localparam int F_FSEL_LO = 10;
    localparam int F_OBE     = 9;
    localparam int F_IBE     = 8;
    localparam int F_DRV_LO  = 6;
    localparam int F_ODE     = 5;
    localparam int F_HYS     = 4;
    localparam int F_SLEW_LO = 2;
    localparam int F_PEN     = 1;
    localparam int F_PSEL    = 0;

    localparam logic [CFG_W-1:0] MASK_STD  = 16'h0F3F;
    localparam logic [CFG_W-1:0] MASK_DRV  = 16'h0FF3;
    localparam logic [CFG_W-1:0] BOOT_INIT = 16'h0001;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACCESS = 2'd1,
        ST_ACK    = 2'd2
    } bus_state_e;

    typedef enum logic [1:0] {
        RGN_CFG  = 2'd0,
        RGN_DOUT = 2'd1,
        RGN_DIN  = 2'd2,
        RGN_NONE = 2'd3
    } region_e;

endpackage

// File: rtl/gpio_bus_fsm.sv
module gpio_bus_fsm
    import gpio_pad_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [3:0]        be,
    input  logic [31:0]       wdata,
    input  logic [31:0]       rd_word,
    output logic              wr_stb,
    output logic [ADDR_W-1:0] addr_q,
    output logic [3:0]        be_q,
    output logic [31:0]       wdata_q,
    output logic [31:0]       rdata,
    output logic              ack
);

    bus_state_e state_q, state_d;
    logic       we_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req) state_d = ST_ACCESS;
            ST_ACCESS: state_d = ST_ACK;
            ST_ACK:    state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_q    <= 1'b0;
            addr_q  <= '0;
            be_q    <= '0;
            wdata_q <= '0;
            rdata   <= '0;
        end else begin
            if (state_q == ST_IDLE && req) begin
                we_q    <= we;
                addr_q  <= addr;
                be_q    <= be;
                wdata_q <= wdata;
            end
            if (state_q == ST_ACCESS) rdata <= rd_word;
        end
    end

    always_comb begin
        wr_stb = (state_q == ST_ACCESS) && we_q;
        ack    = (state_q == ST_ACK);
    end

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end

endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux
    import gpio_pad_pkg::*;
#(
    parameter bit INPUT_ONLY = 1'b0
) (
    input  logic [FSEL_W-1:0]      fsel,
    input  logic                   obe,
    input  logic                   ode,
    input  logic                   dout,
    input  logic [ALT_PER_PIN-1:0] alt_do,
    input  logic [ALT_PER_PIN-1:0] alt_oe,
    output logic                   pad_do,
    output logic                   pad_oe
);

    logic src_d, src_e, drv_en;

    always_comb begin
        unique case (fsel)
            2'd0:    begin src_d = dout;      src_e = obe;       end
            2'd1:    begin src_d = alt_do[0]; src_e = alt_oe[0]; end
            2'd2:    begin src_d = alt_do[1]; src_e = alt_oe[1]; end
            default: begin src_d = alt_do[2]; src_e = alt_oe[2]; end
        endcase

        if (ode) begin
            pad_do = 1'b0;
            drv_en = src_e & ~src_d;
        end else begin
            pad_do = src_d;
            drv_en = src_e;
        end

        pad_oe = INPUT_ONLY ? 1'b0 : drv_en;
    end

endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl
    import gpio_pad_pkg::*;
#(
    parameter int                  NUM_PINS        = 8,
    parameter int                  ADDR_W          = 10,
    parameter logic [NUM_PINS-1:0] INPUT_ONLY_MASK = 8'b0000_0011,
    parameter logic [NUM_PINS-1:0] ABSENT_MASK     = 8'b0100_0000,
    parameter logic [NUM_PINS-1:0] DS_MASK         = 8'b1000_0000,
    parameter int                  BOOT_PIN        = 5
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            bus_req,
    input  logic                            bus_we,
    input  logic [ADDR_W-1:0]               bus_addr,
    input  logic [3:0]                      bus_be,
    input  logic [31:0]                     bus_wdata,
    output logic [31:0]                     bus_rdata,
    output logic                            bus_ack,
    input  logic [NUM_PINS*ALT_PER_PIN-1:0] alt_do,
    input  logic [NUM_PINS*ALT_PER_PIN-1:0] alt_oe,
    input  logic [NUM_PINS-1:0]             pad_di,
    output logic [NUM_PINS-1:0]             pad_do,
    output logic [NUM_PINS-1:0]             pad_oe,
    output logic [NUM_PINS-1:0]             pad_ie,
    output logic [NUM_PINS-1:0]             pad_pull_en,
    output logic [NUM_PINS-1:0]             pad_pull_up,
    output logic [NUM_PINS-1:0]             pad_hys,
    output logic [2*NUM_PINS-1:0]           pad_slew,
    output logic [2*NUM_PINS-1:0]           pad_drive
);

    localparam int WIDX_W  = 6;
    localparam int RGN_LSB = WIDX_W;
    localparam int MAP_MSB = RGN_LSB + 2;

    logic              wr_stb;
    logic [ADDR_W-1:0] addr_q;
    logic [3:0]        be_q;
    logic [31:0]       wdata_q;
    logic [31:0]       rd_word;
    logic [31:0]       rd_parts [NUM_PINS];

    logic [NUM_PINS-1:0] dout_q, din_s, obe_v, ode_v, gpio_v;

    logic              in_map;
    region_e           rgn;
    logic [WIDX_W-1:0] widx;

    assign in_map = (addr_q[ADDR_W-1:MAP_MSB] == '0);
    assign rgn    = region_e'(addr_q[MAP_MSB-1:RGN_LSB]);
    assign widx   = addr_q[WIDX_W-1:0];

    gpio_bus_fsm #(.ADDR_W(ADDR_W)) fsm_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (bus_req),
        .we      (bus_we),
        .addr    (bus_addr),
        .be      (bus_be),
        .wdata   (bus_wdata),
        .rd_word (rd_word),
        .wr_stb  (wr_stb),
        .addr_q  (addr_q),
        .be_q    (be_q),
        .wdata_q (wdata_q),
        .rdata   (bus_rdata),
        .ack     (bus_ack)
    );

    gpio_in_sync #(.WIDTH(NUM_PINS)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pad_di),
        .q     (din_s)
    );

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        localparam logic [WIDX_W-1:0] CW   = WIDX_W'(p / 2);
        localparam logic [WIDX_W-1:0] DW   = WIDX_W'(p / 4);
        localparam int                HL   = (p % 2 == 0) ? 16 : 0;
        localparam int                LANE = 3 - (p % 4);
        localparam logic [CFG_W-1:0]  MASK = DS_MASK[p] ? MASK_DRV : MASK_STD;
        localparam logic [CFG_W-1:0]  INIT = (p == BOOT_PIN) ? BOOT_INIT : '0;
        localparam bit HAS_DOUT = !(INPUT_ONLY_MASK[p] || ABSENT_MASK[p]);

        logic [CFG_W-1:0] cfg_r, cfg_new;
        logic             cfg_hit;
        logic [31:0]      part;

        assign cfg_hit = wr_stb && in_map && (rgn == RGN_CFG) && (widx == CW);
        assign cfg_new = {be_q[HL/8+1] ? wdata_q[HL+8 +: 8] : cfg_r[15:8],
                          be_q[HL/8]   ? wdata_q[HL   +: 8] : cfg_r[7:0]};

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       cfg_r <= INIT;
            else if (cfg_hit) cfg_r <= cfg_new & MASK;
        end

        if (HAS_DOUT) begin : g_dout
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    dout_q[p] <= 1'b0;
                else if (wr_stb && in_map && rgn == RGN_DOUT && widx == DW && be_q[LANE])
                    dout_q[p] <= wdata_q[LANE*8];
            end
        end else begin : g_no_dout
            assign dout_q[p] = 1'b0;
        end

        gpio_pad_mux #(.INPUT_ONLY(INPUT_ONLY_MASK[p])) mux_i (
            .fsel   (cfg_r[F_FSEL_LO +: FSEL_W]),
            .obe    (cfg_r[F_OBE]),
            .ode    (cfg_r[F_ODE]),
            .dout   (dout_q[p]),
            .alt_do (alt_do[p*ALT_PER_PIN +: ALT_PER_PIN]),
            .alt_oe (alt_oe[p*ALT_PER_PIN +: ALT_PER_PIN]),
            .pad_do (pad_do[p]),
            .pad_oe (pad_oe[p])
        );

        assign pad_ie[p]          = cfg_r[F_IBE];
        assign pad_pull_en[p]     = cfg_r[F_PEN];
        assign pad_pull_up[p]     = cfg_r[F_PSEL];
        assign pad_hys[p]         = cfg_r[F_HYS];
        assign pad_slew[2*p +: 2]  = cfg_r[F_SLEW_LO +: 2];
        assign pad_drive[2*p +: 2] = cfg_r[F_DRV_LO +: 2];

        assign obe_v[p]  = cfg_r[F_OBE];
        assign ode_v[p]  = cfg_r[F_ODE];
        assign gpio_v[p] = (cfg_r[F_FSEL_LO +: FSEL_W] == '0);

        always_comb begin
            part = '0;
            if (in_map) begin
                case (rgn)
                    RGN_CFG:  if (widx == CW) part[HL +: 16] = cfg_r;
                    RGN_DOUT: if (widx == DW) part[LANE*8] = dout_q[p];
                    RGN_DIN:  if (widx == DW) part[LANE*8] = din_s[p] & cfg_r[F_IBE];
                    default:  part = '0;
                endcase
            end
        end

        assign rd_parts[p] = part;
    end

    always_comb begin
        rd_word = '0;
        for (int i = 0; i < NUM_PINS; i++) rd_word |= rd_parts[i];
    end

endmodule

// File: rtl/gpio_pad_ctrl_chk.sv
module gpio_pad_ctrl_chk #(
    parameter int                  NUM_PINS        = 8,
    parameter logic [NUM_PINS-1:0] INPUT_ONLY_MASK = 8'b0000_0011
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_req,
    input logic                bus_ack,
    input logic                wr_stb,
    input logic [NUM_PINS-1:0] dout_q,
    input logic [NUM_PINS-1:0] obe_v,
    input logic [NUM_PINS-1:0] ode_v,
    input logic [NUM_PINS-1:0] gpio_v,
    input logic [NUM_PINS-1:0] pad_oe,
    input logic [NUM_PINS-1:0] pad_do
);

    AST_ACK_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |=> !bus_ack); // R12

    AST_ACK_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |-> $past(bus_req, 2)); // R12

    AST_DOUT_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb |=> $stable(dout_q)); // R4

    AST_INPUT_ONLY_NO_OE: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & INPUT_ONLY_MASK) == '0); // R9

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_chk
        AST_OPEN_DRAIN_NO_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
            ode_v[p] |-> !(pad_oe[p] && pad_do[p])); // R8

        if (!INPUT_ONLY_MASK[p]) begin : g_out
            AST_GPIO_OE_TRACKS_OBE: assert property (@(posedge clk) disable iff (!rst_n)
                (gpio_v[p] && !ode_v[p]) |-> (pad_oe[p] == obe_v[p])); // R5
        end
    end

endmodule

bind gpio_pad_ctrl gpio_pad_ctrl_chk #(
    .NUM_PINS        (NUM_PINS),
    .INPUT_ONLY_MASK (INPUT_ONLY_MASK)
) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .bus_req (bus_req),
    .bus_ack (bus_ack),
    .wr_stb  (wr_stb),
    .dout_q  (dout_q),
    .obe_v   (obe_v),
    .ode_v   (ode_v),
    .gpio_v  (gpio_v),
    .pad_oe  (pad_oe),
    .pad_do  (pad_do)
);

// File: tb/gpio_pad_ctrl_tb_top.sv
module gpio_pad_ctrl_tb_top;

    localparam int N  = 8;
    localparam int AW = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_req = 1'b0;
    logic          bus_we = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [3:0]    bus_be = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          bus_ack;
    logic [3*N-1:0] alt_do = '0;
    logic [3*N-1:0] alt_oe = '0;
    logic [N-1:0]  pad_di = '0;
    logic [N-1:0]  pad_do, pad_oe, pad_ie, pad_pull_en, pad_pull_up, pad_hys;
    logic [2*N-1:0] pad_slew, pad_drive;

    int checks = 0;
    int errors = 0;

    logic [31:0] exp_q [$];
    bit          cmp_q [$];
    string       tag_q [$];

    always #2 clk = ~clk;

    gpio_pad_ctrl dut_i (
        .clk (clk), .rst_n (rst_n),
        .bus_req (bus_req), .bus_we (bus_we), .bus_addr (bus_addr),
        .bus_be (bus_be), .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata), .bus_ack (bus_ack),
        .alt_do (alt_do), .alt_oe (alt_oe), .pad_di (pad_di),
        .pad_do (pad_do), .pad_oe (pad_oe), .pad_ie (pad_ie),
        .pad_pull_en (pad_pull_en), .pad_pull_up (pad_pull_up),
        .pad_hys (pad_hys), .pad_slew (pad_slew), .pad_drive (pad_drive)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops one scoreboard item per acknowledge
    always @(negedge clk) begin
        if (rst_n && bus_ack) begin
            if (exp_q.size() == 0) begin
                chk("R12 unexpected ack", 32'd1, 32'd0);
            end else begin
                logic [31:0] e;
                bit          c;
                string       t;
                e = exp_q.pop_front();
                c = cmp_q.pop_front();
                t = tag_q.pop_front();
                if (c) chk(t, bus_rdata, e);
            end
        end
    end

    task automatic xfer(input bit we, input logic [AW-1:0] a, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        bus_req = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d; bus_be = be;
        @(negedge clk);
        bus_req = 1'b0;
        while (!bus_ack) @(negedge clk);
        @(negedge clk);
        chk("R12 ack lasts one cycle", 32'(bus_ack), 32'd0);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d, input logic [3:0] be);
        exp_q.push_back('0); cmp_q.push_back(1'b0); tag_q.push_back("write");
        xfer(1'b1, a, d, be);
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [31:0] e, input string tag);
        exp_q.push_back(e); cmp_q.push_back(1'b1); tag_q.push_back(tag);
        xfer(1'b0, a, 32'h0, 4'h0);
    endtask

    task automatic finish_run;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R12 watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 ack low", 32'(bus_ack), 32'd0);
        chk("R1 no output enables", 32'(pad_oe), 32'h0);
        chk("R1 boot pin pull select", 32'(pad_pull_up), 32'h20);
        chk("R1 pull enables", 32'(pad_pull_en), 32'h0);
        rd(10'h002, 32'h0000_0001, "R1 boot config word");
        rd(10'h000, 32'h0, "R1 config word 0");
        rd(10'h003, 32'h0, "R1 config word 3");
        rd(10'h040, 32'h0, "R1 output data word 0");
        rd(10'h041, 32'h0, "R1 output data word 1");

        // R2 standard field mask and pass-through
        wr(10'h001, 32'hFFFF_FFFF, 4'hF);
        rd(10'h001, 32'h0F3F_0F3F, "R2 standard mask");
        chk("R2 pull enable pin 2", 32'(pad_pull_en[2]), 32'd1);
        chk("R2 hysteresis pin 3", 32'(pad_hys[3]), 32'd1);
        chk("R2 slew pin 2", 32'(pad_slew[5:4]), 32'd3);
        chk("R2 no drive on standard pin", 32'(pad_drive[5:4]), 32'd0);
        wr(10'h001, 32'h0, 4'hF);

        // R3 drive-strength pin
        wr(10'h003, 32'hFFFF_FFFF, 4'hF);
        rd(10'h003, 32'h0F3F_0FF3, "R3 drive pin mask");
        chk("R3 drive field pin 7", 32'(pad_drive[15:14]), 32'd3);
        chk("R3 slew zero pin 7", 32'(pad_slew[15:14]), 32'd0);
        wr(10'h003, 32'h0, 4'hF);

        // R4 byte-lane output data writes
        wr(10'h040, 32'hFFFF_FFFF, 4'b0010);
        rd(10'h040, 32'h0000_0100, "R4 lane 1 only");
        wr(10'h040, 32'h0101_0101, 4'b0001);
        rd(10'h040, 32'h0000_0101, "R4 lane 0 added");
        chk("R5 obe off keeps pads released", 32'(pad_oe[3:2]), 32'd0);

        // R6 preloaded data appears on direction flip
        wr(10'h001, 32'h0200_0000, 4'b1100);
        chk("R6 oe after flip", 32'(pad_oe[2]), 32'd1);
        chk("R6 preloaded data on pad", 32'(pad_do[2]), 32'd1);
        chk("R5 neighbour pin untouched", 32'(pad_oe[3]), 32'd0);

        // R9 input-only pins
        wr(10'h000, 32'h0200_0200, 4'hF);
        chk("R9 input-only never enabled", 32'(pad_oe[1:0]), 32'd0);
        rd(10'h000, 32'h0200_0200, "R9 config still writable");
        wr(10'h040, 32'hFFFF_FFFF, 4'b1100);
        rd(10'h040, 32'h0000_0101, "R9 input-only data ignored");

        // R4 only bit 0 of each lane stored
        wr(10'h040, 32'hFEFE_FEFE, 4'hF);
        rd(10'h040, 32'h0, "R4 upper lane bits dropped");
        chk("R5 pad follows data", 32'(pad_do[2]), 32'd0);

        // R8 open drain
        wr(10'h001, 32'h0220_0000, 4'b1100);
        wr(10'h040, 32'h0000_0100, 4'b0010);
        chk("R8 data 1 releases", 32'(pad_oe[2]), 32'd0);
        wr(10'h040, 32'h0, 4'b0010);
        chk("R8 data 0 enables", 32'(pad_oe[2]), 32'd1);
        chk("R8 data 0 drives low", 32'(pad_do[2]), 32'd0);

        // R7 alternate function 2 on pin 3 (index 10)
        @(negedge clk);
        alt_do = '0; alt_do[10] = 1'b1;
        alt_oe = '0; alt_oe[10] = 1'b1;
        wr(10'h001, 32'h0000_0800, 4'b0011);
        chk("R7 alt data", 32'(pad_do[3]), 32'd1);
        chk("R7 alt enable", 32'(pad_oe[3]), 32'd1);
        wr(10'h040, 32'h0000_0001, 4'b0001);
        @(negedge clk);
        alt_do[10] = 1'b0;
        alt_oe = ~(24'd1 << 10);
        #1;
        chk("R7 gpio data has no effect", 32'(pad_do[3]), 32'd0);
        chk("R7 alt enable selects index", 32'(pad_oe[3]), 32'd0);
        rd(10'h040, 32'h0000_0001, "R7 data still stored");
        rd(10'h001, 32'h0220_0800, "R7 neighbour config kept");

        // R10 absent pin and gaps
        wr(10'h041, 32'hFFFF_FFFF, 4'hF);
        rd(10'h041, 32'h0101_0001, "R10 absent pin reads zero");
        wr(10'h042, 32'hFFFF_FFFF, 4'hF);
        rd(10'h042, 32'h0, "R10 empty word");
        rd(10'h004, 32'h0, "R10 empty config word");
        rd(10'h0C0, 32'h0, "R10 unmapped region");

        // R11 synchronized input readback
        @(negedge clk);
        pad_di = 8'b0011_0000;
        repeat (3) @(negedge clk);
        rd(10'h081, 32'h0, "R11 gated without input enable");
        wr(10'h002, 32'h0100_0000, 4'b1100);
        chk("R11 input enable pad", 32'(pad_ie[4]), 32'd1);
        rd(10'h081, 32'h0100_0000, "R11 enabled pin visible");
        pad_di[4] = 1'b0;
        repeat (3) @(negedge clk);
        rd(10'h081, 32'h0, "R11 follows pin low");
        rd(10'h002, 32'h0100_0001, "R1 boot bit preserved");

        repeat (2) @(negedge clk);
        chk("R12 scoreboard drained", 32'(exp_q.size()), 32'd0);
        finish_run();
    end

endmodule